// File: doc/BRIEF.md
# Register Pending-Write Scoreboard

This block tracks, for every architectural register of an in-order five-stage pipeline, how many issued instructions still owe it a result. Decode announces each instruction that will write a register through an allocate port. Writeback reports each completed write through a writeback port. Two source lookup ports report whether a register holds its final value, so decode knows whether it must stall.

A single ready flag per register is not enough here. When two writers to the same register are in flight, the older writer's writeback would set the flag even though the younger result has not arrived, and a dependent reader would take a stale value. The block avoids this by keeping a small counter per register. A register is ready only when its count is zero. A lookup made in the same cycle as the last outstanding writeback already sees the register as ready, because the register file delivers that value in the same cycle.

Register 0 is hard-wired and is never tracked. When a register's counter is full, the allocate port reports a stall and the allocation is not counted.

Top module: `reg_pend_scoreboard`

## Requirements
- R1: After reset every register has a count of zero, and both lookup ports report ready for any register.
- R2: An accepted allocation to register r (r not 0) adds one to r's count, and a lookup of r reports not ready from the next cycle on.
- R3: Each writeback to r with a non-zero count removes one. r reads ready only when its count is zero, so with two writers outstanding, one writeback leaves r not ready.
- R4: A lookup of r reports ready in the same cycle as a writeback to r whose count is exactly one (same-cycle write-then-read).
- R5: An accepted allocation and a writeback to the same register in the same cycle leave that register's count unchanged.
- R6: The count saturates at 2^CNT_W-1 (3 by default). An allocate to a register at that count raises alloc_stall in the same cycle and is not counted. alloc_stall is low whenever alloc_valid is low.
- R7: Register 0 is not tracked. Allocations to it never change state and never stall, and lookups of it always report ready.
- R8: A writeback to a register whose count is zero is ignored. Its count stays zero and does not wrap.
- R9: The two lookup ports are independent. Each reports the readiness of its own register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode issues an instruction that writes alloc_rd |
| alloc_rd | input | IDX_W (5) | Destination register of the issuing instruction |
| alloc_stall | output | 1 | Allocation refused because the destination count is full |
| wb_valid | input | 1 | A result is written back this cycle |
| wb_rd | input | IDX_W (5) | Destination register of the writeback |
| qa_rs | input | IDX_W (5) | Register looked up on port A |
| qa_ready | output | 1 | Port A register has no outstanding writer |
| qb_rs | input | IDX_W (5) | Register looked up on port B |
| qb_ready | output | 1 | Port B register has no outstanding writer |

## Verification
The counting function is driven with four patterns. Two overlapping writers followed by staggered writebacks show that a count is kept rather than a single flag. A writer that issues in the same cycle an older writer retires checks that the count is held. Four writers to one register exercise saturation and the refused allocation. Writebacks to idle registers check that the count does not underflow. Each lookup is sampled both in the writeback cycle and the cycle after, which separates same-cycle visibility from registered readiness. Register 0 and untouched registers on the second port confirm that no state leaks between entries.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INC  = 2'd1,
        ACT_DEC  = 2'd2
    } cnt_act_e;

    // allocate and retire together cancel out
    function automatic cnt_act_e pick_act(input logic inc, input logic dec);
        cnt_act_e a;
        if (inc && !dec)      a = ACT_INC;
        else if (dec && !inc) a = ACT_DEC;
        else                  a = ACT_HOLD;
        return a;
    endfunction

endpackage

// File: rtl/rps_dest_decode.sv
module rps_dest_decode #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                valid_i,
    input  logic [IDX_W-1:0]    idx_i,
    output logic [NUM_REGS-1:0] hit_o
);
    always_comb begin
        hit_o = '0;
        for (int r = 1; r < NUM_REGS; r++) begin
            if (valid_i && (idx_i == IDX_W'(r))) hit_o[r] = 1'b1;
        end
    end
endmodule

// File: rtl/rps_pend_cell.sv
module rps_pend_cell #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o,
    output logic             full_o
);
    import rps_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cell_st_t;

    cell_st_t st_d, st_q;
    cnt_act_e act;

    always_comb begin
        st_d = st_q;
        act  = pick_act(inc_i, dec_i);
        case (act)
            ACT_INC: st_d.cnt = st_q.cnt + CNT_W'(1);
            ACT_DEC: st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign zero_o = (st_q.cnt == '0);
    assign full_o = (st_q.cnt == CNT_MAX);

    // R6: the top must never ask a full counter to grow
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && inc_i && !dec_i));
    // R8: the top must never ask an empty counter to shrink
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(zero_o && dec_i));
    // R2: a lone allocate raises the count by one
    p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
    // R3: a lone retire lowers the count by one
    p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));
    // R5: allocate with retire keeps the count
    p_pair_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rps_ready_lookup.sv
module rps_ready_lookup #(
    parameter int NUM_REGS = 32,
    parameter int CNT_W    = 2,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rs_i,
    input  logic [CNT_W-1:0] cnt_i [NUM_REGS],
    input  logic             wb_valid_i,
    input  logic [IDX_W-1:0] wb_rd_i,
    output logic             ready_o
);
    logic [CNT_W-1:0] sel_cnt;
    logic             last_retire;

    always_comb begin
        sel_cnt     = cnt_i[rs_i];
        // the final outstanding writer lands this cycle: value readable now
        last_retire = wb_valid_i && (wb_rd_i == rs_i) && (sel_cnt == CNT_W'(1));
        ready_o     = (rs_i == '0) || (sel_cnt == '0) || last_retire;
    end

    // R7: register 0 always reads ready
    p_zero_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_i == '0) |-> ready_o);
    // R3: two or more writers outstanding means not ready
    p_multi_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rs_i != '0) && (sel_cnt > CNT_W'(1))) |-> !ready_o);
endmodule

// File: rtl/reg_pend_scoreboard.sv
module reg_pend_scoreboard #(
    parameter int NUM_REGS = 32,
    parameter int CNT_W    = 2,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [IDX_W-1:0] alloc_rd,
    output logic             alloc_stall,
    input  logic             wb_valid,
    input  logic [IDX_W-1:0] wb_rd,
    input  logic [IDX_W-1:0] qa_rs,
    output logic             qa_ready,
    input  logic [IDX_W-1:0] qb_rs,
    output logic             qb_ready
);
    localparam int NUM_PORTS = 2;

    logic [NUM_REGS-1:0] alloc_hit, wb_hit;
    logic [NUM_REGS-1:0] inc_v, dec_v, zero_v, full_v;
    logic [CNT_W-1:0]    cnt_w [NUM_REGS];
    logic [IDX_W-1:0]    q_rs  [NUM_PORTS];
    logic [NUM_PORTS-1:0] q_rdy;

    rps_dest_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_alloc_dec (
        .valid_i(alloc_valid), .idx_i(alloc_rd), .hit_o(alloc_hit)
    );
    rps_dest_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_wb_dec (
        .valid_i(wb_valid), .idx_i(wb_rd), .hit_o(wb_hit)
    );

    assign cnt_w[0]  = '0;
    assign zero_v[0] = 1'b1;
    assign full_v[0] = 1'b0;
    assign inc_v[0]  = 1'b0;
    assign dec_v[0]  = 1'b0;

    for (genvar r = 1; r < NUM_REGS; r++) begin : g_cell
        assign inc_v[r] = alloc_hit[r] && !full_v[r];
        assign dec_v[r] = wb_hit[r] && !zero_v[r];
        rps_pend_cell #(.CNT_W(CNT_W)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .inc_i(inc_v[r]), .dec_i(dec_v[r]),
            .cnt_o(cnt_w[r]), .zero_o(zero_v[r]), .full_o(full_v[r])
        );
    end

    assign alloc_stall = |(alloc_hit & full_v);

    assign q_rs[0] = qa_rs;
    assign q_rs[1] = qb_rs;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rps_ready_lookup #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_look (
            .clk(clk), .rst_n(rst_n),
            .rs_i(q_rs[p]), .cnt_i(cnt_w),
            .wb_valid_i(wb_valid), .wb_rd_i(wb_rd),
            .ready_o(q_rdy[p])
        );
    end

    assign qa_ready = q_rdy[0];
    assign qb_ready = q_rdy[1];

    // R6: a stall only answers a request
    p_stall_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_stall |-> alloc_valid);
    // R7: register 0 never stalls
    p_r0_no_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_rd == '0) |-> !alloc_stall);
    // R2: an accepted allocation makes the register busy next cycle
    p_alloc_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_stall && alloc_rd != '0 && qa_rs == alloc_rd && !wb_valid)
        |=> ((qa_rs != $past(alloc_rd)) || !qa_ready || wb_valid));
endmodule

// File: tb/tb_reg_pend_scoreboard.sv
`timescale 1ns/1ps
module tb_reg_pend_scoreboard;
    localparam int NR = 32;
    localparam int IW = 5;
    localparam int CMAX = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0, wb_valid = 1'b0;
    logic [IW-1:0] alloc_rd = '0, wb_rd = '0, qa_rs = '0, qb_rs = '0;
    logic alloc_stall, qa_ready, qb_ready;

    always #2 clk = ~clk;

    reg_pend_scoreboard dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_rd(alloc_rd), .alloc_stall(alloc_stall),
        .wb_valid(wb_valid), .wb_rd(wb_rd),
        .qa_rs(qa_rs), .qa_ready(qa_ready),
        .qb_rs(qb_rs), .qb_ready(qb_ready)
    );

    typedef struct {
        string tag;
        string what;
        int    sel;
        logic  exp;
    } item_t;

    item_t exp_q[$];
    event  chk_ev;
    int    n_vec = 0;
    int    n_bad = 0;
    int    model [NR];
    bit    done = 1'b0;

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                logic act;
                it = exp_q.pop_front();
                act = (it.sel == 0) ? qa_ready : (it.sel == 1) ? qb_ready : alloc_stall;
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s %s actual=%0b expected=%0b", it.tag, it.what, act, it.exp);
                end
            end
        end
    end

    function automatic logic exp_ready(int rs);
        if (rs == 0) return 1'b1;
        if (model[rs] == 0) return 1'b1;
        if (model[rs] == 1 && wb_valid && int'(wb_rd) == rs) return 1'b1;
        return 1'b0;
    endfunction

    // driver: one cycle of stimulus, expected items, then model update
    task automatic step(input bit av, input int ard, input bit wv, input int wrd,
                        input int ars, input int brs, input string tag);
        item_t it;
        logic st;
        @(negedge clk);
        alloc_valid = av; alloc_rd = IW'(ard);
        wb_valid = wv; wb_rd = IW'(wrd);
        qa_rs = IW'(ars); qb_rs = IW'(brs);
        #0.5;
        st = av && ard != 0 && model[ard] == CMAX;
        it.tag = tag; it.what = "qa_ready";    it.sel = 0; it.exp = exp_ready(ars); exp_q.push_back(it);
        it.tag = tag; it.what = "qb_ready";    it.sel = 1; it.exp = exp_ready(brs); exp_q.push_back(it);
        it.tag = tag; it.what = "alloc_stall"; it.sel = 2; it.exp = st;             exp_q.push_back(it);
        -> chk_ev;
        @(posedge clk);
        begin
            bit inc, dec;
            inc = av && ard != 0 && !st;
            dec = wv && wrd != 0 && model[wrd] > 0;
            if (inc && !dec) model[ard] = model[ard] + 1;
            else if (dec && !inc) model[wrd] = model[wrd] - 1;
        end
    endtask

    initial begin
        for (int i = 0; i < NR; i++) model[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: everything ready after reset
        step(0, 0, 0, 0, 5, 31, "R1");
        step(0, 0, 0, 0, 1, 17, "R1");
        // R2: allocate r5, busy next cycle; R9 port B independent
        step(1, 5, 0, 0, 5, 6, "R2");
        step(0, 0, 0, 0, 5, 6, "R2");
        step(0, 0, 0, 0, 6, 5, "R9");
        // R3: second writer, first retire leaves not ready
        step(1, 5, 0, 0, 5, 5, "R3");
        step(0, 0, 1, 5, 5, 0, "R3");
        step(0, 0, 0, 0, 5, 6, "R3");
        // R4: last retire visible in same cycle
        step(0, 0, 1, 5, 5, 5, "R4");
        step(0, 0, 0, 0, 5, 5, "R4");
        // R5: allocate + retire same register
        step(1, 7, 0, 0, 7, 8, "R5");
        step(1, 7, 1, 7, 7, 7, "R5");
        step(0, 0, 0, 0, 7, 7, "R5");
        step(0, 0, 1, 7, 7, 8, "R5");
        step(0, 0, 0, 0, 7, 7, "R5");
        // R6: saturation and refused allocation
        step(1, 9, 0, 0, 9, 10, "R6");
        step(1, 9, 0, 0, 9, 10, "R6");
        step(1, 9, 0, 0, 9, 10, "R6");
        step(1, 9, 0, 0, 9, 10, "R6");
        step(1, 9, 1, 9, 9, 10, "R6");
        step(0, 9, 0, 0, 9, 10, "R6");
        step(0, 0, 1, 9, 9, 9, "R6");
        step(0, 0, 1, 9, 9, 9, "R6");
        step(0, 0, 1, 9, 9, 9, "R6");
        step(0, 0, 0, 0, 9, 9, "R6");
        // R7: register 0
        step(1, 0, 0, 0, 0, 0, "R7");
        step(1, 0, 1, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 11, "R7");
        // R8: writeback to idle register ignored
        step(0, 0, 1, 12, 12, 12, "R8");
        step(0, 0, 1, 12, 12, 13, "R8");
        step(1, 12, 0, 0, 12, 13, "R8");
        step(0, 0, 0, 0, 12, 13, "R8");
        step(0, 0, 1, 12, 12, 12, "R8");
        step(0, 0, 0, 0, 12, 12, "R8");
        // R9: both ports on different busy/idle registers
        step(1, 20, 0, 0, 20, 21, "R9");
        step(1, 21, 0, 0, 20, 21, "R9");
        step(0, 0, 0, 0, 21, 20, "R9");
        step(0, 0, 1, 20, 20, 21, "R9");
        step(0, 0, 1, 21, 20, 21, "R9");
        step(0, 0, 0, 0, 20, 21, "R9");
        @(negedge clk);
        -> chk_ev;
        #1;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule